// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the software-facing register layer of an SPI master. A simple single-cycle bus reads and writes ten 32-bit registers at word offsets 0 to 9. Writes to the transmit-data word go straight into an external transmit FIFO, and reads of the receive-data word pop an external receive FIFO. The block also holds the control, configuration, interrupt-enable, DMA, period and test words, and it drives four active-low chip selects. It decides when the serial engine must start a transfer and when a soft reset must flush the FIFOs and the engine's burst counter.

The shifting engine and the status and interrupt logic sit outside the block. The status word is read from an input port. Writes to it are passed out as a one-cycle strobe with the written data, so that the status logic can apply them. A small state machine tracks the block with four states: OFF (disabled), ON (enabled and idle), START (issues the one-cycle start pulse) and RESET (issues the one-cycle flush pulse). Its transitions are:

- Any control write with enable clear leads to RESET.
- A start trigger leads to START.
- Another control write leads to ON.
- START falls back to ON, and RESET falls back to OFF.

Top module: `spi_regif`

## Requirements
- R1: Word offsets are: 0 receive data, 1 transmit data, 2 control, 3 configuration, 4 interrupt enable, 5 DMA, 6 status, 7 period, 8 test, 9 message data. A read at offset 10 or above returns 0, and a write there changes nothing. Read data appears on `bus_rdata` in the cycle after the read and is 0 after a cycle with no read.
- R2: A read of offset 0 returns 0 while control bit 0 (enable) is clear. With enable set, it returns 32'hDEADBEEF if the receive FIFO is empty. Otherwise it asserts `rxf_pop` in the same cycle and returns `rxf_data`.
- R3: Reads of offsets 1 and 9 return 0. Writes to offsets 0 and 9 push nothing, pop nothing and alter no register.
- R4: A write to offset 1 asserts `txf_push` with `txf_data` equal to the written word in the same cycle, but only when enable is set and `txf_full` is low. Otherwise the write is dropped.
- R5: A push while the selected channel is master and control bit 3 (start mode) is set gives `xfer_start` high in the next cycle. A push without both conditions gives no start.
- R6: A control write with bit 0 clear zeroes every stored register. In the next cycle it gives `fifo_flush` high for exactly one cycle and all chip selects high.
- R7: The control layout is: bits 7:4 channel mode (one bit per channel, 1 = master) and bits 19:18 channel select. On a control write with enable set, if the selected channel's mode bit is 1, `cs_n` becomes all ones except a 0 at the selected channel. If that bit is 0, `cs_n` keeps its value. Reset value is 4'hF.
- R8: A control write with enable set and the selected channel master starts a transfer (`xfer_start` high next cycle) in either of two cases. The first is start mode rising from 0 to 1 while `txf_empty` is low. The second is bit 2 (exchange) rising from 0 to 1 while the new start mode bit is 0.
- R9: Offsets 2, 3, 4, 5, 7 and 8 read back the last word written. Offset 6 reads `status_in`. A write to offset 6 asserts `stat_wr` with `stat_wdata` equal to the word in the same cycle.
- R10: `xfer_start` and `fifo_flush` are never high together, and each lasts one cycle per trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| txf_push | output | 1 | Push strobe to transmit FIFO |
| txf_data | output | 32 | Word to push |
| txf_full | input | 1 | Transmit FIFO full |
| txf_empty | input | 1 | Transmit FIFO empty |
| rxf_pop | output | 1 | Pop strobe to receive FIFO |
| rxf_data | input | 32 | Receive FIFO head entry |
| rxf_empty | input | 1 | Receive FIFO empty |
| status_in | input | 32 | Status word from the status logic |
| stat_wr | output | 1 | Status write strobe |
| stat_wdata | output | 32 | Status write data |
| ctrl_word | output | 32 | Control register contents |
| cfg_word | output | 32 | Configuration register contents |
| ien_word | output | 32 | Interrupt enable register contents |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| fifo_flush | output | 1 | One-cycle soft-reset pulse for FIFOs and burst counter |
| cs_n | output | 4 | Active-low chip selects |

## Verification
Three outputs are combinational from the bus in the access cycle: `txf_push`, `rxf_pop` and `stat_wr`. Four outputs come from registers and change at the edge that ends the access: `bus_rdata`, `cs_n`, `xfer_start` and `fifo_flush`. The bench drives each access at a falling edge and samples the combinational strobes 1 ns later. It samples the registered results at the next falling edge, half a cycle after the capturing edge. A check of pulse length uses one extra idle cycle. The bench sweeps all 64 offsets, all 64 combinations of channel mode and channel select, and every start-trigger case, and computes each expected word arithmetically.

// File: rtl/spi_rif_pkg.sv
package spi_rif_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_REGS = 10;
    localparam int NUM_CS   = 4;
    localparam int SEL_W    = 2;

    localparam int OFS_RX   = 0;
    localparam int OFS_TX   = 1;
    localparam int OFS_CTRL = 2;
    localparam int OFS_CFG  = 3;
    localparam int OFS_IEN  = 4;
    localparam int OFS_DMA  = 5;
    localparam int OFS_STAT = 6;
    localparam int OFS_PER  = 7;
    localparam int OFS_TEST = 8;
    localparam int OFS_MSG  = 9;

    localparam int B_EN   = 0;
    localparam int B_XCH  = 2;
    localparam int B_SMC  = 3;
    localparam int B_MODE = 4;
    localparam int B_SEL  = 18;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_START = 2'd2,
        ST_RESET = 2'd3
    } rif_state_e;

    function automatic bit is_storage(input int ofs);
        return (ofs == OFS_CTRL) || (ofs == OFS_CFG) || (ofs == OFS_IEN) ||
               (ofs == OFS_DMA)  || (ofs == OFS_PER) || (ofs == OFS_TEST);
    endfunction
endpackage

// File: rtl/spi_rif_decode.sv
module spi_rif_decode
    import spi_rif_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [NUM_REGS-1:0] rd_sel
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        logic hit;
        assign hit       = bus_valid && (bus_addr == ADDR_W'(i));
        assign wr_sel[i] = hit && bus_write;
        assign rd_sel[i] = hit && !bus_write;
    end
endmodule

// File: rtl/spi_rif_regs.sv
module spi_rif_regs
    import spi_rif_pkg::*;
#(
    parameter logic [REG_W-1:0] EMPTY_MARK = 32'hDEADBEEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [NUM_REGS-1:0] rd_sel,
    input  logic [REG_W-1:0]    wdata,
    input  logic [REG_W-1:0]    rxf_data,
    input  logic                rxf_empty,
    input  logic [REG_W-1:0]    status_in,
    output logic [REG_W-1:0]    ctrl_word,
    output logic [REG_W-1:0]    cfg_word,
    output logic [REG_W-1:0]    ien_word,
    output logic [REG_W-1:0]    rdata
);
    logic [REG_W-1:0] regval [NUM_REGS];
    logic [REG_W-1:0] rd_val;
    logic             soft_clr;

    assign soft_clr = wr_sel[OFS_CTRL] && !wdata[B_EN];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (is_storage(i)) begin : g_store
            logic [REG_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (soft_clr) begin
                    q <= '0;
                end else if (wr_sel[i]) begin
                    q <= wdata;
                end
            end
            assign regval[i] = q;
        end else begin : g_none
            assign regval[i] = '0;
        end
    end

    assign ctrl_word = regval[OFS_CTRL];
    assign cfg_word  = regval[OFS_CFG];
    assign ien_word  = regval[OFS_IEN];

    always_comb begin
        rd_val = '0;
        if (rd_sel[OFS_RX]) begin
            if (!ctrl_word[B_EN]) begin
                rd_val = '0;
            end else if (rxf_empty) begin
                rd_val = EMPTY_MARK;
            end else begin
                rd_val = rxf_data;
            end
        end else if (rd_sel[OFS_STAT]) begin
            rd_val = status_in;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (rd_sel[i]) begin
                    rd_val = regval[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_val;
        end
    end
endmodule

// File: rtl/spi_rif_fsm.sv
module spi_rif_fsm
    import spi_rif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              new_en,
    input  logic              new_xch,
    input  logic              new_smc,
    input  logic [NUM_CS-1:0] new_mode,
    input  logic [SEL_W-1:0]  new_sel,
    input  logic              cur_xch,
    input  logic              cur_smc,
    input  logic [NUM_CS-1:0] cur_mode,
    input  logic [SEL_W-1:0]  cur_sel,
    input  logic              tx_push,
    input  logic              txf_empty,
    output logic              xfer_start,
    output logic              fifo_flush,
    output logic [NUM_CS-1:0] cs_n
);
    rif_state_e state_q, state_d;
    logic new_master, cur_master;
    logic ctrl_trig, push_trig;

    assign new_master = new_mode[new_sel];
    assign cur_master = cur_mode[cur_sel];

    assign ctrl_trig = ctrl_wr && new_en && new_master &&
                       ((new_smc && !cur_smc && !txf_empty) ||
                        (new_xch && !cur_xch && !new_smc));
    assign push_trig = tx_push && cur_master && cur_smc;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr && !new_en) begin
            state_d = ST_RESET;
        end else if (ctrl_trig || push_trig) begin
            state_d = ST_START;
        end else if (ctrl_wr) begin
            state_d = ST_ON;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_ON:    state_d = ST_ON;
                ST_START: state_d = ST_ON;
                ST_RESET: state_d = ST_OFF;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        xfer_start = 1'b0;
        fifo_flush = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_ON:    ;
            ST_START: xfer_start = 1'b1;
            ST_RESET: fifo_flush = 1'b1;
            default:  ;
        endcase
    end

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_n[c] <= 1'b1;
            end else if (ctrl_wr) begin
                if (!new_en) begin
                    cs_n[c] <= 1'b1;
                end else if (new_master) begin
                    cs_n[c] <= (new_sel != SEL_W'(c));
                end
            end
        end
    end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_rif_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [31:0] EMPTY_MARK = 32'hDEADBEEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              txf_push,
    output logic [31:0]       txf_data,
    input  logic              txf_full,
    input  logic              txf_empty,
    output logic              rxf_pop,
    input  logic [31:0]       rxf_data,
    input  logic              rxf_empty,
    input  logic [31:0]       status_in,
    output logic              stat_wr,
    output logic [31:0]       stat_wdata,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       cfg_word,
    output logic [31:0]       ien_word,
    output logic              xfer_start,
    output logic              fifo_flush,
    output logic [3:0]        cs_n
);
    localparam int MIN_ADDR_W = $clog2(NUM_REGS);
    if (ADDR_W < MIN_ADDR_W) begin : g_bad_width
        initial $error("ADDR_W too small for register map");
    end

    logic [NUM_REGS-1:0] wr_sel, rd_sel;
    logic                enabled;

    spi_rif_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    spi_rif_regs #(.EMPTY_MARK(EMPTY_MARK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .wdata     (bus_wdata),
        .rxf_data  (rxf_data),
        .rxf_empty (rxf_empty),
        .status_in (status_in),
        .ctrl_word (ctrl_word),
        .cfg_word  (cfg_word),
        .ien_word  (ien_word),
        .rdata     (bus_rdata)
    );

    assign enabled    = ctrl_word[B_EN];
    assign txf_push   = wr_sel[OFS_TX] && enabled && !txf_full;
    assign txf_data   = bus_wdata;
    assign rxf_pop    = rd_sel[OFS_RX] && enabled && !rxf_empty;
    assign stat_wr    = wr_sel[OFS_STAT];
    assign stat_wdata = bus_wdata;

    spi_rif_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_sel[OFS_CTRL]),
        .new_en     (bus_wdata[B_EN]),
        .new_xch    (bus_wdata[B_XCH]),
        .new_smc    (bus_wdata[B_SMC]),
        .new_mode   (bus_wdata[B_MODE +: NUM_CS]),
        .new_sel    (bus_wdata[B_SEL +: SEL_W]),
        .cur_xch    (ctrl_word[B_XCH]),
        .cur_smc    (ctrl_word[B_SMC]),
        .cur_mode   (ctrl_word[B_MODE +: NUM_CS]),
        .cur_sel    (ctrl_word[B_SEL +: SEL_W]),
        .tx_push    (txf_push),
        .txf_empty  (txf_empty),
        .xfer_start (xfer_start),
        .fifo_flush (fifo_flush),
        .cs_n       (cs_n)
    );
endmodule

// File: rtl/spi_rif_chk.sv
module spi_rif_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              txf_push,
    input logic              txf_full,
    input logic              rxf_pop,
    input logic              rxf_empty,
    input logic [31:0]       ctrl_word,
    input logic              xfer_start,
    input logic              fifo_flush,
    input logic [3:0]        cs_n
);
    logic master_now;
    assign master_now = ctrl_word[4 + int'(ctrl_word[19:18])];

    p_oob_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr >= ADDR_W'(10))) |=> (bus_rdata == 32'd0));

    p_pop_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |-> (ctrl_word[0] && !rxf_empty));

    p_push_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        txf_push |-> (ctrl_word[0] && !txf_full));

    p_push_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txf_push && ctrl_word[3] && master_now) |=> xfer_start);

    p_flush_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (ctrl_word == 32'd0 && cs_n == 4'hF));

    p_cs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_start && fifo_flush));

    p_flush_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (!fifo_flush || $past(bus_valid && bus_write && bus_addr == ADDR_W'(2))));
endmodule

bind spi_regif spi_rif_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .txf_push   (txf_push),
    .txf_full   (txf_full),
    .rxf_pop    (rxf_pop),
    .rxf_empty  (rxf_empty),
    .ctrl_word  (ctrl_word),
    .xfer_start (xfer_start),
    .fifo_flush (fifo_flush),
    .cs_n       (cs_n)
);

// File: tb/sim_spi_regif.sv
`timescale 1ns/1ps
module sim_spi_regif;
    localparam int AW = 6;
    localparam logic [31:0] EN = 32'h1, XCH = 32'h4, SMC = 32'h8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 0, bus_write = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic txf_push, txf_full = 0, txf_empty = 1;
    logic [31:0] txf_data;
    logic rxf_pop, rxf_empty = 1;
    logic [31:0] rxf_data = '0, status_in = 32'h0000_00C3;
    logic stat_wr;
    logic [31:0] stat_wdata, ctrl_word, cfg_word, ien_word;
    logic xfer_start, fifo_flush;
    logic [3:0] cs_n;

    int n_cmp = 0, n_bad = 0;
    logic c_push, c_pop, c_stw;
    logic [31:0] c_txd, c_swd;
    logic s_start, s_flush;
    logic [3:0] s_cs;

    spi_regif #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txf_push(txf_push), .txf_data(txf_data), .txf_full(txf_full),
        .txf_empty(txf_empty), .rxf_pop(rxf_pop), .rxf_data(rxf_data),
        .rxf_empty(rxf_empty), .status_in(status_in), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .ctrl_word(ctrl_word), .cfg_word(cfg_word),
        .ien_word(ien_word), .xfer_start(xfer_start), .fifo_flush(fifo_flush),
        .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input int a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_addr = AW'(a); bus_wdata = d;
        #1;
        c_push = txf_push; c_pop = rxf_pop; c_stw = stat_wr;
        c_txd = txf_data; c_swd = stat_wdata;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        s_start = xfer_start; s_flush = fifo_flush; s_cs = cs_n;
    endtask

    task automatic idle();
        @(negedge clk);
        s_start = xfer_start; s_flush = fifo_flush; s_cs = cs_n;
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'h5A00_0000 | (32'(a) * 32'h0001_0203);
    endfunction

    function automatic bit plain(input int a);
        return a == 3 || a == 4 || a == 5 || a == 7 || a == 8;
    endfunction

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] prev_cs;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R7 reset cs_n", 32'(cs_n), 32'hF);
        chk("R10 reset start", 32'(xfer_start), 0);
        chk("R10 reset flush", 32'(fifo_flush), 0);
        chk("R1 reset rdata", bus_rdata, 0);

        // R2 disabled receive read
        rxf_empty = 0; rxf_data = 32'h1234_5678;
        access(0, 0, 0);
        chk("R2 disabled rx value", bus_rdata, 0);
        chk("R2 disabled no pop", 32'(c_pop), 0);
        access(1, 1, 32'h77);
        chk("R4 disabled no push", 32'(c_push), 0);

        access(1, 2, EN);
        chk("R9 ctrl out", ctrl_word, EN);
        chk("R10 enable no pulse", 32'(s_start | s_flush), 0);

        // R3 ignored writes
        access(1, 9, 32'hFFFF_FFFF);
        chk("R3 msg write no push", 32'(c_push | c_pop), 0);
        access(1, 0, 32'hFFFF_FFFF);
        chk("R3 rx write no push/pop", 32'(c_push | c_pop), 0);

        // R1/R9 sweep of the whole address space
        for (int a = 3; a < 9; a++) if (plain(a)) access(1, a, pat(a));
        for (int a = 10; a < 64; a++) access(1, a, 32'hFFFF_FFFF);
        for (int a = 1; a < 64; a++) begin
            logic [31:0] e;
            access(0, a, 0);
            if (a == 2) e = EN;
            else if (plain(a)) e = pat(a);
            else if (a == 6) e = status_in;
            else e = 0;
            chk($sformatf("R1 R9 R3 read ofs %0d", a), bus_rdata, e);
        end
        idle();
        chk("R1 rdata idle zero", bus_rdata, 0);
        chk("R9 cfg out", cfg_word, pat(3));
        chk("R9 ien out", ien_word, pat(4));

        access(1, 6, 32'h0000_0081);
        chk("R9 status strobe", 32'(c_stw), 1);
        chk("R9 status data", c_swd, 32'h81);
        access(0, 6, 0);
        chk("R9 status unchanged by write", bus_rdata, status_in);

        // R2 enabled
        rxf_empty = 1;
        access(0, 0, 0);
        chk("R2 empty marker", bus_rdata, 32'hDEADBEEF);
        chk("R2 empty no pop", 32'(c_pop), 0);
        rxf_empty = 0; rxf_data = 32'hCAFE_0001;
        access(0, 0, 0);
        chk("R2 pop value", bus_rdata, 32'hCAFE_0001);
        chk("R2 pop strobe", 32'(c_pop), 1);

        // R4
        txf_full = 0;
        access(1, 1, 32'h11);
        chk("R4 push", 32'(c_push), 1);
        chk("R4 push data", c_txd, 32'h11);
        chk("R5 no start non-master", 32'(s_start), 0);
        txf_full = 1;
        access(1, 1, 32'h12);
        chk("R4 full drop", 32'(c_push), 0);
        txf_full = 0;

        // R7 sweep over mode and select
        prev_cs = 4'hF;
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [3:0] e;
                access(1, 2, EN | (32'(m) << 4) | (32'(s) << 18));
                e = m[s] ? ~(4'b1 << s) : prev_cs;
                chk($sformatf("R7 cs mode %0h sel %0d", m, s), 32'(s_cs), 32'(e));
                chk("R8 no start plain write", 32'(s_start), 0);
                prev_cs = e;
            end
        end

        // R5 push trigger
        txf_empty = 1;
        access(1, 2, EN | SMC | 32'hF0 | (32'd1 << 18));
        chk("R8 smc rise empty no start", 32'(s_start), 0);
        chk("R7 cs sel1", 32'(s_cs), 32'hD);
        access(1, 1, 32'h22);
        chk("R4 push master", 32'(c_push), 1);
        chk("R5 start after push", 32'(s_start), 1);
        idle();
        chk("R10 start one cycle", 32'(s_start), 0);
        access(1, 2, EN | SMC);
        access(1, 1, 32'h23);
        chk("R5 push non-master no start", 32'(s_start), 0);

        // R8 control triggers
        txf_empty = 0;
        access(1, 2, EN | 32'hF0);
        chk("R8 smc drop no start", 32'(s_start), 0);
        access(1, 2, EN | SMC | 32'hF0);
        chk("R8 smc rise start", 32'(s_start), 1);
        access(1, 2, EN | 32'hF0);
        chk("R8 plain no start", 32'(s_start), 0);
        access(1, 2, EN | XCH | 32'hF0);
        chk("R8 xch rise start", 32'(s_start), 1);
        access(1, 2, EN | XCH | 32'hF0);
        chk("R8 xch held no start", 32'(s_start), 0);
        access(1, 2, EN | 32'hF0);
        txf_empty = 1;
        access(1, 2, EN | XCH | SMC | 32'hF0);
        chk("R8 xch with smc no start", 32'(s_start), 0);
        access(1, 2, EN);
        access(1, 2, EN | XCH);
        chk("R8 xch non-master no start", 32'(s_start), 0);

        // R6 soft reset
        access(1, 2, EN | 32'hF0 | (32'd2 << 18));
        chk("R7 cs sel2", 32'(s_cs), 32'hB);
        access(1, 2, 32'hFFFF_FFFE);
        chk("R6 flush pulse", 32'(s_flush), 1);
        chk("R6 cs high", 32'(s_cs), 32'hF);
        chk("R10 no start with flush", 32'(s_start), 0);
        idle();
        chk("R6 flush one cycle", 32'(s_flush), 0);
        for (int a = 2; a < 9; a++) begin
            if (a == 2 || plain(a)) begin
                access(0, a, 0);
                chk($sformatf("R6 cleared ofs %0d", a), bus_rdata, 0);
            end
        end
        rxf_empty = 0;
        access(0, 0, 0);
        chk("R2 after reset rx zero", bus_rdata, 0);
        access(1, 1, 32'h33);
        chk("R4 after reset no push", 32'(c_push), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule